// File: doc/BRIEF.md
# I2C Target Byte-Event Controller

This block is an I2C bus target (slave) that sits behind a system clock domain. It oversamples the SCL and SDA wires, recognises START, repeated START and STOP conditions, matches the first byte of each transfer against a programmable 7-bit own address, shifts data bytes in and out, and controls SDA through an open-drain pull-down enable. It does not interpret the data itself. Everything that happens on the bus is handed to an attached backend as one-cycle byte events, and the backend answers each event in the same cycle.

There are five events. Write-requested and read-requested mark an address match with R/W at 0 and at 1. Write-received carries one incoming data byte. Read-processed asks for the next outgoing byte. Stop marks the end of the transfer. For a received byte, the backend decides whether the byte is ACKed. For read events, it supplies a byte. The next outgoing byte is fetched as soon as the current byte starts to leave, so the backend has a whole byte time to answer. When the master NACKs, that prefetched byte is thrown away.

Top module: `i2c_evt_target`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sda_oe is 0 and evt_valid is 0.
- R2: A START is SDA falling while the synchronised SCL is high. The first byte after it is taken MSB first: bits 7..1 are the address and bit 0 is R/W. A match with R/W = 0 emits event code 0 (write-requested) with evt_wdata = 0. The backend's answer to this event has no effect.
- R3: A match with R/W = 1 emits event code 1 (read-requested). The byte on be_rdata in that event cycle is the first data byte sent, MSB first.
- R4: A matching address is always ACKed (SDA pulled low in the 9th clock), whatever be_nack holds. A non-matching address is not ACKed and raises no event.
- R5: After a write address, each 8 received data bits emit event code 2 (write-received) with the byte on evt_wdata. The byte is ACKed if be_nack is 0 in that event cycle and NACKed (SDA released) otherwise.
- R6: On the SCL falling edge that starts each outgoing byte, the target drives that byte's MSB and emits event code 3 (read-processed). The byte returned then is the one sent after a master ACK. The byte already being shifted out is not altered by it.
- R7: After a master NACK, the target releases SDA and raises no data events. The prefetched byte is dropped, and the next read-requested event supplies a fresh first byte.
- R8: A STOP (SDA rising while SCL high) returns the target to idle. It emits event code 4 if the own address matched at any point since the previous STOP, including in the middle of a byte (then no write-received event follows). Without a match, a STOP emits nothing.
- R9: A repeated START during a transfer restarts address reception and emits no stop event.
- R10: SDA is driven only through sda_oe (1 = pull low), and sda_oe changes only while the synchronised SCL is low.
- R11: Every event is a single-cycle pulse, one cycle after the bus condition that causes it. evt_code is at most 4, and evt_wdata is 0 for all events except write-received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Own 7-bit target address |
| scl_i | input | 1 | SCL wire level (asynchronous) |
| sda_i | input | 1 | SDA wire level (asynchronous) |
| be_rdata | input | 8 | Backend byte, sampled in read-requested and read-processed event cycles |
| be_nack | input | 1 | Backend refusal, sampled in write-received event cycles |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| evt_valid | output | 1 | Event strobe, one cycle |
| evt_code | output | 3 | 0 write-req, 1 read-req, 2 write-recv, 3 read-proc, 4 stop |
| evt_wdata | output | 8 | Received byte for write-received, 0 otherwise |

## Verification
Two actions share one SCL falling edge in a read:
- the byte fetched earlier starts moving into the shifter, and its MSB is driven onto SDA;
- the fetch of the following byte is issued.

The backend's answer to that fetch arrives in the very next cycle. To provoke the overlap, the bench backend returns a different byte at every read event, by advancing a pointer into a computed table. The master then reads several bytes with ACKs and ends with a NACK. The check is that the master receives the table entries in order, so no byte was overwritten by its successor. A later read must start at the entry after the discarded prefetch, not at the discarded one.

// File: rtl/i2c_evt_pkg.sv
// Shared definitions for the I2C target event controller.
// Event codes are visible at the top-level port, so their values are fixed.
package i2c_evt_pkg;

    typedef enum logic [2:0] {
        EV_WR_REQ  = 3'd0,
        EV_RD_REQ  = 3'd1,
        EV_WR_RCV  = 3'd2,
        EV_RD_PROC = 3'd3,
        EV_STOP    = 3'd4
    } evt_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,      // not selected, waiting for START
        ST_ADDR,      // shifting in the address byte
        ST_WDAT,      // shifting in a write data byte
        ST_ACK_PEND,  // ACK/NACK decided, waiting for SCL low to drive it
        ST_ACK_HOLD,  // ACK/NACK on the bus, waiting for SCL low to end it
        ST_RDAT,      // shifting out a read data byte
        ST_MACK,      // waiting for the master's ACK bit
        ST_RNEXT      // master ACKed, next byte starts at SCL low
    } eng_state_e;

endpackage

// File: rtl/i2c_evt_sync.sv
// Multi-stage synchroniser for one asynchronous wire.
// Assumes: the input is a slow bus level. The reset value matches the idle
// bus level, so no false edge appears when reset ends.
module i2c_evt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_chain
            // Purpose: shift the wire level through the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_evt_cond.sv
// Bus condition detector: synchronises SCL/SDA and turns them into
// single-cycle SCL edge, START and STOP pulses.
// Assumes: the system clock is several times faster than SCL, so each SCL
// phase spans many clock cycles.
module i2c_evt_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    i2c_evt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_lvl)
    );

    i2c_evt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_lvl)
    );

    // Purpose: keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  =  scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl &  scl_q;
    assign start_det =  scl_lvl &  scl_q &  sda_q & ~sda_lvl;
    assign stop_det  =  scl_lvl &  scl_q & ~sda_q &  sda_lvl;

endmodule

// File: rtl/i2c_evt_engine.sv
// Transfer engine: address match, byte shifting, ACK control, open-drain
// SDA enable and backend event generation.
// Assumes: ADDR_W == DATA_W - 1 (address plus R/W fills one byte). The
// backend answers combinationally in the cycle where evt_valid is high.
module i2c_evt_engine
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] be_rdata,
    input  logic              be_nack,
    output logic              sda_oe,
    output logic              evt_valid,
    output evt_code_e         evt_code,
    output logic [DATA_W-1:0] evt_wdata
);

    localparam int                CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  LAST_RX = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  FULL_TX = CNT_W'(DATA_W);

    eng_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] tx_hold;
    logic [DATA_W-1:0] rx_byte;
    logic              ack_q;
    logic              rd_mode;
    logic              sel;
    logic              rsp_rd;
    logic              rsp_wr;

    assign rx_byte = {rx_sh[DATA_W-2:0], sda_lvl};
    assign rsp_rd  = evt_valid && (evt_code == EV_RD_REQ || evt_code == EV_RD_PROC);
    assign rsp_wr  = evt_valid && (evt_code == EV_WR_RCV);

    // Purpose: bus-phase sequencing, shifting, SDA enable and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_hold   <= '0;
            ack_q     <= 1'b0;
            rd_mode   <= 1'b0;
            sel       <= 1'b0;
            sda_oe    <= 1'b0;
            evt_valid <= 1'b0;
            evt_code  <= EV_WR_REQ;
            evt_wdata <= '0;
        end else begin
            evt_valid <= 1'b0;
            // backend answers are taken at the edge ending the event cycle
            if (rsp_rd) tx_hold <= be_rdata;
            if (rsp_wr) ack_q   <= ~be_nack;

            if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
                sel    <= 1'b0;
                if (sel) begin
                    evt_valid <= 1'b1;
                    evt_code  <= EV_STOP;
                    evt_wdata <= '0;
                end
            end else if (start_det) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (scl_rise) begin
                        rx_sh <= rx_byte;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_RX) begin
                            if (rx_sh[ADDR_W-1:0] == own_addr) begin
                                sel       <= 1'b1;
                                ack_q     <= 1'b1;
                                rd_mode   <= sda_lvl;
                                evt_valid <= 1'b1;
                                evt_code  <= sda_lvl ? EV_RD_REQ : EV_WR_REQ;
                                evt_wdata <= '0;
                                st        <= ST_ACK_PEND;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_WDAT: if (scl_rise) begin
                        rx_sh <= rx_byte;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_RX) begin
                            rd_mode   <= 1'b0;
                            evt_valid <= 1'b1;
                            evt_code  <= EV_WR_RCV;
                            evt_wdata <= rx_byte;
                            st        <= ST_ACK_PEND;
                        end
                    end
                    ST_ACK_PEND: if (scl_fall) begin
                        sda_oe <= ack_q;
                        st     <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (scl_fall) begin
                        if (rd_mode) begin
                            tx_sh     <= tx_hold;
                            sda_oe    <= ~tx_hold[DATA_W-1];
                            cnt       <= CNT_W'(1);
                            evt_valid <= 1'b1;
                            evt_code  <= EV_RD_PROC;
                            evt_wdata <= '0;
                            st        <= ST_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_WDAT;
                        end
                    end
                    ST_RDAT: if (scl_fall) begin
                        if (cnt == FULL_TX) begin
                            sda_oe <= 1'b0;
                            st     <= ST_MACK;
                        end else begin
                            sda_oe <= ~tx_sh[DATA_W-2];
                            tx_sh  <= tx_sh << 1;
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_MACK: if (scl_rise) begin
                        st <= sda_lvl ? ST_IDLE : ST_RNEXT;
                    end
                    ST_RNEXT: if (scl_fall) begin
                        tx_sh     <= tx_hold;
                        sda_oe    <= ~tx_hold[DATA_W-1];
                        cnt       <= CNT_W'(1);
                        evt_valid <= 1'b1;
                        evt_code  <= EV_RD_PROC;
                        evt_wdata <= '0;
                        st        <= ST_RDAT;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_evt_target.sv
// I2C target with a byte-event backend interface.
// Assumes: SCL from the master never stretches; the system clock runs many
// times faster than SCL; own_addr is static during a transfer.
module i2c_evt_target #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] be_rdata,
    input  logic              be_nack,
    output logic              sda_oe,
    output logic              evt_valid,
    output logic [2:0]        evt_code,
    output logic [DATA_W-1:0] evt_wdata
);

    logic scl_lvl;
    logic sda_lvl;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;
    i2c_evt_pkg::evt_code_e code_e;

    i2c_evt_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_evt_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (own_addr),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .be_rdata  (be_rdata),
        .be_nack   (be_nack),
        .sda_oe    (sda_oe),
        .evt_valid (evt_valid),
        .evt_code  (code_e),
        .evt_wdata (evt_wdata)
    );

    assign evt_code = code_e;

endmodule

// File: rtl/i2c_evt_target_chk.sv
// Property checker for i2c_evt_target, attached by bind below.
// Assumes: the SDA wire can only change level while the target leaves it released.
module i2c_evt_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       evt_valid,
    input logic [2:0] evt_code,
    input logic [7:0] evt_wdata
);

    // R10: open-drain enable is steady across a high SCL phase
    assert_oe_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R11: events last one cycle
    assert_evt_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    // R11: only defined codes appear
    assert_evt_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code <= 3'd4));

    // R11: data field is zero except for received bytes
    assert_wdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code != 3'd2) |-> (evt_wdata == 8'd0));

    // R8: a stop event follows a detected STOP condition
    assert_stop_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd4) |-> $past(stop_det));

    // R6: read-processed follows an SCL falling edge
    assert_rdproc_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd3) |-> $past(scl_fall));

    // R5: write-received follows an SCL rising edge
    assert_wrcv_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd2) |-> $past(scl_rise));

endmodule

bind i2c_evt_target i2c_evt_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_wdata (evt_wdata)
);

// File: tb/i2c_evt_target_test.sv
// Bench: behavioural I2C master, pointer-based backend, and a per-clock
// monitor comparing events against an expected queue.
module i2c_evt_target_test;

    localparam int Q        = 12;      // clocks per quarter SCL period
    localparam int WATCHDOG = 200000;
    localparam logic [6:0] OWN = 7'h3A;

    typedef struct packed {
        logic [2:0] c;
        logic [7:0] d;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       nack_all = 1'b0;
    logic       sda_oe;
    logic       evt_valid;
    logic [2:0] evt_code;
    logic [7:0] evt_wdata;
    logic [7:0] be_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    int  compared = 0;
    int  mismatched = 0;
    int  n_stop = 0;
    int  ptr;
    logic wfirst;
    logic run = 1'b0;
    logic finished = 1'b0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    logic evp = 1'b0;
    ev_t exp_q[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_f(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R5";
            3'd3:    return "R6";
            default: return "R8";
        endcase
    endfunction

    assign be_rdata = mem_f(ptr);

    i2c_evt_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (OWN),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .be_rdata  (be_rdata),
        .be_nack   (nack_all),
        .sda_oe    (sda_oe),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .evt_wdata (evt_wdata)
    );

    // backend model: pointer into a computed table
    always @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= 0;
            wfirst <= 1'b0;
        end else if (evt_valid) begin
            case (evt_code)
                3'd0: wfirst <= 1'b1;
                3'd2: begin
                    if (wfirst) ptr <= int'(evt_wdata);
                    wfirst <= 1'b0;
                end
                3'd1, 3'd3: ptr <= ptr + 1;
                default: ;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] c, input logic [7:0] d);
        exp_q.push_back('{c: c, d: d});
    endtask

    // per-clock monitor
    always @(negedge clk) begin
        if (run && !finished) begin
            if (scl_m && scl_prev) chk("R10 oe steady while SCL high", 32'(sda_oe), 32'(oe_prev));
            if (evt_valid) begin
                chk("R11 single-cycle event", 32'(evp), 32'd0);
                if (evt_code == 3'd4) n_stop++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected event", 32'({evt_code, evt_wdata}), 32'hFFFF);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(tag_of(e.c), 32'({evt_code, evt_wdata}), 32'({e.c, e.d}));
                end
            end
            oe_prev  = sda_oe;
            scl_prev = scl_m;
            evp      = evt_valid;
        end
    end

    task automatic q_wait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic m_stop;
        sda_m = 1'b0; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b1; q_wait();
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b;    q_wait();
        scl_m = 1'b1; q_wait();
        r = sda_line; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, ack);
    endtask

    task automatic m_rbyte(input logic nack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(nack, r);
    endtask

    task automatic drained(input string tag);
        repeat (4 * Q) @(negedge clk);
        chk(tag, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic a;
        logic r;
        logic [7:0] d;
        int stops_before;

        repeat (10) @(negedge clk);
        chk("R1 sda_oe after reset", 32'(sda_oe), 32'd0);
        chk("R1 evt_valid after reset", 32'(evt_valid), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b1;

        // two-byte write
        push(3'd0, 8'h00); push(3'd2, 8'h05); push(3'd2, 8'hC3); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b0}, a); chk("R4 address ACK on write", 32'(a), 32'd0);
        m_wbyte(8'h05, a);       chk("R5 data ACK", 32'(a), 32'd0);
        m_wbyte(8'hC3, a);       chk("R5 second data ACK", 32'(a), 32'd0);
        m_stop();
        drained("R8 write events complete");

        // pointer write, repeated START, three-byte read
        push(3'd0, 8'h00); push(3'd2, 8'h10); push(3'd1, 8'h00);
        push(3'd3, 8'h00); push(3'd3, 8'h00); push(3'd3, 8'h00); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b0}, a); chk("R4 address ACK", 32'(a), 32'd0);
        m_wbyte(8'h10, a);       chk("R5 pointer ACK", 32'(a), 32'd0);
        stops_before = n_stop;
        m_start();
        m_wbyte({OWN, 1'b1}, a); chk("R4 address ACK on read", 32'(a), 32'd0);
        chk("R9 no stop event at repeated START", 32'(n_stop), 32'(stops_before));
        m_rbyte(1'b0, d); chk("R3 first read byte", 32'(d), 32'(mem_f(16)));
        m_rbyte(1'b0, d); chk("R6 second read byte", 32'(d), 32'(mem_f(17)));
        m_rbyte(1'b1, d); chk("R6 third read byte", 32'(d), 32'(mem_f(18)));
        m_stop();
        drained("R9 read events complete");

        // fresh first byte after a discarded prefetch
        push(3'd1, 8'h00); push(3'd3, 8'h00); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        m_rbyte(1'b1, d); chk("R7 fresh first byte", 32'(d), 32'(mem_f(20)));
        chk("R7 SDA released after master NACK", 32'(sda_oe), 32'd0);
        m_stop();
        drained("R7 events complete");

        // backend refuses data, address still ACKed
        nack_all = 1'b1;
        push(3'd0, 8'h00); push(3'd2, 8'h77); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b0}, a); chk("R4 address ACK despite be_nack", 32'(a), 32'd0);
        m_wbyte(8'h77, a);       chk("R5 data NACK", 32'(a), 32'd1);
        m_stop();
        nack_all = 1'b0;
        drained("R5 refused write events complete");

        // foreign address: no ACK, no events, no stop event
        stops_before = n_stop;
        m_start();
        m_wbyte({OWN ^ 7'h01, 1'b0}, a); chk("R4 foreign address not ACKed", 32'(a), 32'd1);
        m_stop();
        drained("R4 no events for foreign address");
        chk("R8 no stop event without match", 32'(n_stop), 32'(stops_before));

        // STOP in the middle of a data byte
        push(3'd0, 8'h00); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b1, r);
        m_stop();
        drained("R8 mid-byte stop");

        // target ready again after the aborted byte
        push(3'd0, 8'h00); push(3'd2, 8'h5A); push(3'd4, 8'h00);
        m_start();
        m_wbyte({OWN, 1'b0}, a); chk("R8 address ACK after abort", 32'(a), 32'd0);
        m_wbyte(8'h5A, a);       chk("R2 data ACK after abort", 32'(a), 32'd0);
        m_stop();
        drained("R2 events after abort");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule